// File: doc/BRIEF.md
# Serial-Bus Audio Control Register Slave

This block is the control port of a stereo audio processor. It is a slave on a two-wire I2C bus. It receives configuration bytes into a small register file and presents the decoded fields as steady outputs:

- per-channel volume codes;
- output mute and line mute;
- stereo mode;
- automatic level control enable, decay boost and attack time;
- tone preset, source select, forced mono and flat tone.

A read returns one status byte. That byte carries the stereo-pilot indication and a sticky flag that marks a reset since the last completed read.

Both bus lines are oversampled by a system clock that runs at least 16 times the bus clock rate. The block itself never holds the clock line low. It drives the data line only through an open-drain enable. One address bit comes from a select pin, so two of these devices can share a bus.

A write sends a subaddress byte and then any number of data bytes. The pointer steps through the four registers and wraps back to the first. A START that arrives at any point abandons the current transfer and begins a new address phase.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: The device acknowledges only the 7-bit address 101101x, where x equals `addr_sel_i`. The select pin high gives 0x5B; the select pin low gives 0x5A.
- R2: In a write, the first byte after the address selects the register. Each later byte is stored, and the slave acknowledges every byte of an addressed write.
- R3: Successive data bytes go to registers in the order 0 (right volume), 1 (left volume), 2 (control A), 3 (control B). After register 3 the pointer wraps to 0.
- R4: Only subaddress bits 1:0 select the register, and bits 7:2 are ignored.
- R5: Both volume registers hold their 7-bit code in bits 6:0, and bit 7 is not stored. In control A, the fields are: bit 0 stereo, bit 1 output mute, bit 2 level control on, bit 3 decay boost, bits 5:4 attack, bit 6 line mute. Bit 7 of control A is not stored.
- R6: In control B, the fields are: bits 1:0 tone preset, bit 2 external source, bit 3 forced mono, bit 4 flat tone. Bits 7:5 are not stored.
- R7: A read returns one byte, MSB first. Bit 0 is the pilot input and bit 1 is the reset flag.
- R8: Reset sets the output mute bit and the reset flag, clears all other fields, and returns the bus logic to idle.
- R9: The reset flag clears once a status byte has been fully sent and the ninth clock of the read has risen.
- R10: A START that arrives inside a byte abandons that byte without storing it, and the block restarts address reception.
- R11: After a non-matching address, SDA stays released until the next START.
- R12: The SDA enable only rises while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16x SCL |
| rst_ni | input | 1 | Active-low asynchronous reset, power-on |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_sel_i | input | 1 | Address LSB select |
| pilot_i | input | 1 | Stereo pilot detected |
| vol_r_o | output | 7 | Right volume code |
| vol_l_o | output | 7 | Left volume code |
| stereo_o | output | 1 | Stereo mode for line out |
| gen_mute_o | output | 1 | Output mute |
| avl_on_o | output | 1 | Automatic level control on |
| decay_fast_o | output | 1 | Increased decay current |
| attack_o | output | 2 | Attack time select |
| line_mute_o | output | 1 | Line output mute |
| tone_sel_o | output | 2 | Tone preset |
| src_ext_o | output | 1 | External source select |
| mono_o | output | 1 | Forced mono |
| lin_tone_o | output | 1 | Flat tone |

## Verification
The hardest case to reach from the ports is a repeated START in the middle of a data byte. It must take effect while the shift register is half full and the pointer is already set, and the bytes that follow must land in the right register.

The stimulus handles this in two steps. It sends an address, a subaddress and four data bits. It then raises SDA and SCL and drops SDA while SCL is high. After that it runs a complete write to a different register. The reference model then confirms that the abandoned register kept its value.

A second abort in the middle of the address phase, followed by a read, shows that the address logic restarts from the beginning.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;
  localparam int unsigned REG_NUM = 4;
  localparam int unsigned IDX_W   = $clog2(REG_NUM);
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CNT_W   = $clog2(BYTE_W + 1);
  localparam logic [6:0]  DEV_ADDR_BASE = 7'b1011010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_TX, ST_MACK, ST_IGN
  } bus_st_e;

  typedef struct packed {
    logic [6:0] vol_r;
    logic [6:0] vol_l;
    logic       stereo;
    logic       gen_mute;
    logic       avl_on;
    logic       decay_fast;
    logic [1:0] attack;
    logic       line_mute;
    logic [1:0] tone_sel;
    logic       src_ext;
    logic       mono;
    logic       lin_tone;
  } ctl_fields_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // data edges while clock stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import audio_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             addr_sel_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic             rd_done_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] TOP  = IDX_W'(REG_NUM - 1);

  bus_st_e          st_q;
  logic [CNT_W-1:0] bit_q;
  logic [BYTE_W-1:0] sh_q, tx_q;
  logic             rw_q, addr_ph_q, have_sub_q;
  logic [IDX_W-1:0] ptr_q;
  logic [6:0]       dev_addr;
  logic             byte_end;

  assign dev_addr = {DEV_ADDR_BASE[6:1], addr_sel_i};
  assign byte_end = scl_fall_i && (bit_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bit_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      rw_q       <= 1'b0;
      addr_ph_q  <= 1'b0;
      have_sub_q <= 1'b0;
      ptr_q      <= '0;
    end else if (start_i) begin
      st_q  <= ST_ADDR;
      bit_q <= '0;
    end else if (stop_i) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (scl_rise_i && bit_q != FULL) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            bit_q <= bit_q + 1'b1;
          end else if (byte_end) begin
            if (sh_q[7:1] == dev_addr) begin
              st_q       <= ST_ACK;
              rw_q       <= sh_q[0];
              addr_ph_q  <= 1'b1;
              have_sub_q <= 1'b0;
            end else begin
              st_q <= ST_IGN;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            bit_q     <= '0;
            addr_ph_q <= 1'b0;
            if (addr_ph_q && rw_q) begin
              st_q <= ST_TX;
              tx_q <= status_i;
            end else begin
              st_q <= ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise_i && bit_q != FULL) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            bit_q <= bit_q + 1'b1;
          end else if (byte_end) begin
            st_q <= ST_ACK;
            if (!have_sub_q) begin
              ptr_q      <= sh_q[IDX_W-1:0];
              have_sub_q <= 1'b1;
            end else begin
              ptr_q <= (ptr_q == TOP) ? '0 : ptr_q + 1'b1;
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (bit_q == LAST) st_q <= ST_MACK;
            else begin
              tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_MACK: if (scl_rise_i) st_q <= ST_IGN;
        default: ;
      endcase
    end
  end

  assign sda_oe_o  = (st_q == ST_ACK) || (st_q == ST_TX && !tx_q[BYTE_W-1]);
  assign wr_en_o   = (st_q == ST_RX) && byte_end && have_sub_q && !start_i && !stop_i;
  assign wr_idx_o  = ptr_q;
  assign wr_data_o = sh_q;
  assign rd_done_o = (st_q == ST_MACK) && scl_rise_i && !start_i && !stop_i;

  p_oe_scl_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);
  p_ign_released_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IGN && !start_i) |=> !sda_oe_o);
  p_ptr_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && ptr_q == TOP) |=> ptr_q == '0);
  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st_q == ST_ADDR && bit_q == '0));
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import audio_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_done_i,
  input  logic              pilot_i,
  output logic [BYTE_W-1:0] status_o,
  output ctl_fields_t       fields_o
);
  localparam logic [REG_NUM-1:0][BYTE_W-1:0] WMASK   = {8'h1F, 8'h7F, 8'h7F, 8'h7F};
  localparam logic [REG_NUM-1:0][BYTE_W-1:0] RST_VAL = {8'h00, 8'h02, 8'h00, 8'h00};

  logic [REG_NUM-1:0][BYTE_W-1:0] regs_q;
  logic por_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= RST_VAL;
    end else if (wr_en_i) begin
      for (int i = 0; i < REG_NUM; i++)
        if (wr_idx_i == IDX_W'(i)) regs_q[i] <= wr_data_i & WMASK[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        por_q <= 1'b1;
    else if (rd_done_i) por_q <= 1'b0;
  end

  assign status_o = {{(BYTE_W-2){1'b0}}, por_q, pilot_i};

  always_comb begin
    fields_o.vol_r      = regs_q[0][6:0];
    fields_o.vol_l      = regs_q[1][6:0];
    fields_o.stereo     = regs_q[2][0];
    fields_o.gen_mute   = regs_q[2][1];
    fields_o.avl_on     = regs_q[2][2];
    fields_o.decay_fast = regs_q[2][3];
    fields_o.attack     = regs_q[2][5:4];
    fields_o.line_mute  = regs_q[2][6];
    fields_o.tone_sel   = regs_q[3][1:0];
    fields_o.src_ext    = regs_q[3][2];
    fields_o.mono       = regs_q[3][3];
    fields_o.lin_tone   = regs_q[3][4];
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_q));
  p_por_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(por_q) |-> $past(rd_done_i));
endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave
  import audio_ctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       addr_sel_i,
  input  logic       pilot_i,
  output logic [6:0] vol_r_o,
  output logic [6:0] vol_l_o,
  output logic       stereo_o,
  output logic       gen_mute_o,
  output logic       avl_on_o,
  output logic       decay_fast_o,
  output logic [1:0] attack_o,
  output logic       line_mute_o,
  output logic [1:0] tone_sel_o,
  output logic       src_ext_o,
  output logic       mono_o,
  output logic       lin_tone_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic wr_en, rd_done;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data, status;
  ctl_fields_t       fields;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_proto_fsm u_fsm (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .addr_sel_i, .status_i(status), .sda_oe_o,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .rd_done_o(rd_done)
  );

  ctl_regfile u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_done_i(rd_done), .pilot_i, .status_o(status), .fields_o(fields)
  );

  assign vol_r_o      = fields.vol_r;
  assign vol_l_o      = fields.vol_l;
  assign stereo_o     = fields.stereo;
  assign gen_mute_o   = fields.gen_mute;
  assign avl_on_o     = fields.avl_on;
  assign decay_fast_o = fields.decay_fast;
  assign attack_o     = fields.attack;
  assign line_mute_o  = fields.line_mute;
  assign tone_sel_o   = fields.tone_sel;
  assign src_ext_o    = fields.src_ext;
  assign mono_o       = fields.mono;
  assign lin_tone_o   = fields.lin_tone;
endmodule

// File: tb/sim_audio_ctl_i2c_slave.sv
`timescale 1ns/1ps
module sim_audio_ctl_i2c_slave;
  localparam int CLK_P = 10;
  localparam int Q     = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b1, pilot = 1'b0;
  logic sda_oe;
  logic [6:0] vol_r, vol_l;
  logic stereo, gen_mute, avl_on, decay_fast, line_mute, src_ext, mono, lin_tone;
  logic [1:0] attack, tone_sel;
  wire  sda_line = sda_m & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  audio_ctl_i2c_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .pilot_i(pilot), .vol_r_o(vol_r), .vol_l_o(vol_l),
    .stereo_o(stereo), .gen_mute_o(gen_mute), .avl_on_o(avl_on), .decay_fast_o(decay_fast),
    .attack_o(attack), .line_mute_o(line_mute), .tone_sel_o(tone_sel), .src_ext_o(src_ext),
    .mono_o(mono), .lin_tone_o(lin_tone)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_reg [4];
  logic [7:0] m_mask [4] = '{8'h7F, 8'h7F, 8'h7F, 8'h1F};
  logic m_por;
  logic quiet = 1'b0, expect_rel = 1'b0;
  logic [7:0] wbuf [8];

  function automatic logic [25:0] exp_vec();
    return {m_reg[0][6:0], m_reg[1][6:0], m_reg[2][0], m_reg[2][1], m_reg[2][2], m_reg[2][3],
            m_reg[2][5:4], m_reg[2][6], m_reg[3][1:0], m_reg[3][2], m_reg[3][3], m_reg[3][4]};
  endfunction
  wire [25:0] dut_vec = {vol_r, vol_l, stereo, gen_mute, avl_on, decay_fast, attack,
                         line_mute, tone_sel, src_ext, mono, lin_tone};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model while the bus is quiet (R2 R5 R6)
  always @(negedge clk) begin
    if (quiet && rst_n) chk("R2/R5/R6 field compare", 32'(dut_vec), 32'(exp_vec()));
    if (expect_rel && sda_oe) chk("R11 sda released", 32'(sda_oe), 32'd0);
  end

  task automatic model_reset();
    m_reg = '{8'h00, 8'h00, 8'h02, 8'h00};
    m_por = 1'b1;
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic bus_stop();  sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask
  task automatic put_bit(input logic b); sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq(); endtask
  task automatic get_bit(output logic b); sda_m = 1; wq(); scl_m = 1; wq(); b = sda_line; wq(); scl_m = 0; wq(); endtask
  task automatic put_byte(input logic [7:0] d, output logic ackn);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ackn);
  endtask

  task automatic i2c_write(input logic [6:0] a, input logic [7:0] sub, input int n,
                           input logic match, input string tag);
    logic ackn;
    int p;
    quiet = 0;
    bus_start();
    put_byte({a, 1'b0}, ackn);
    chk({tag, " addr ack"}, 32'(ackn), 32'(!match));
    if (match) begin
      put_byte(sub, ackn);
      chk("R2 sub ack", 32'(ackn), 32'd0);
      p = int'(sub[1:0]);
      for (int i = 0; i < n; i++) begin
        put_byte(wbuf[i], ackn);
        chk("R2 data ack", 32'(ackn), 32'd0);
        m_reg[p] = wbuf[i] & m_mask[p];
        p = (p + 1) % 4;
      end
    end else begin
      expect_rel = 1;
      put_byte(8'h00, ackn);
      chk("R11 no ack on data", 32'(ackn), 32'd1);
      expect_rel = 0;
    end
    bus_stop();
    wq();
    quiet = 1;
  endtask

  task automatic i2c_read(input logic [6:0] a, output logic [7:0] d);
    logic ackn, b;
    quiet = 0;
    d = '0;
    bus_start();
    put_byte({a, 1'b1}, ackn);
    chk("R7 read addr ack", 32'(ackn), 32'd0);
    for (int i = 0; i < 8; i++) begin get_bit(b); d = {d[6:0], b}; end
    put_bit(1'b1);
    m_por = 1'b0;
    bus_stop();
    wq();
    quiet = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] st;
    logic ackn;
    model_reset();
    repeat (4) @(negedge clk);
    // R8 reset state
    chk("R8 gen mute at reset", 32'(gen_mute), 32'd1);
    chk("R8 fields at reset", 32'(dut_vec), 32'(exp_vec()));
    chk("R8 sda idle at reset", 32'(sda_oe), 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    quiet = 1;

    // R7 R8 R9 status reads
    i2c_read(7'h5B, st);
    chk("R8 por flag set", 32'(st[1:0]), 32'b10);
    i2c_read(7'h5B, st);
    chk("R9 por flag cleared", 32'(st[1:0]), 32'b00);
    pilot = 1;
    i2c_read(7'h5B, st);
    chk("R7 pilot bit", 32'(st[1:0]), 32'b01);

    // R2 R5 R6 full sweep with masked top bits
    wbuf[0] = 8'hFF; wbuf[1] = 8'h2A; wbuf[2] = 8'hD5; wbuf[3] = 8'hFF;
    i2c_write(7'h5B, 8'h00, 4, 1, "R2");
    chk("R5 vol_r bit7 dropped", 32'(vol_r), 32'h7F);
    chk("R5 vol_l", 32'(vol_l), 32'h2A);
    chk("R5 ctrl A fields", 32'({line_mute, attack, decay_fast, avl_on, gen_mute, stereo}), 32'h55);
    chk("R6 ctrl B fields", 32'({lin_tone, mono, src_ext, tone_sel}), 32'h1F);

    // R3 wrap from register 3
    wbuf[0] = 8'h0A; wbuf[1] = 8'h11; wbuf[2] = 8'h22;
    i2c_write(7'h5B, 8'h03, 3, 1, "R3");
    chk("R3 wrap to vol_r", 32'(vol_r), 32'h11);
    chk("R3 then vol_l", 32'(vol_l), 32'h22);
    chk("R6 tone/mono", 32'({lin_tone, mono, src_ext, tone_sel}), 32'h0A);

    // R4 upper subaddress bits ignored
    wbuf[0] = 8'h03;
    i2c_write(7'h5B, 8'hFE, 1, 1, "R4");
    chk("R4 sub FE hits control A", 32'({gen_mute, stereo}), 32'b11);

    // R1 R11 wrong address with select high
    i2c_write(7'h5A, 8'h00, 0, 0, "R1");
    // R1 select low
    addr_sel = 0;
    wbuf[0] = 8'h04;
    i2c_write(7'h5A, 8'h03, 1, 1, "R1");
    chk("R1 alt address write", 32'(src_ext), 32'd1);
    i2c_write(7'h5B, 8'h00, 0, 0, "R1");
    addr_sel = 1;

    // R10 abort inside a data byte
    quiet = 0;
    bus_start();
    put_byte({7'h5B, 1'b0}, ackn);
    put_byte(8'h01, ackn);
    put_bit(1); put_bit(0); put_bit(1); put_bit(1);
    wbuf[0] = 8'h33;
    i2c_write(7'h5B, 8'h00, 1, 1, "R10");
    chk("R10 aborted byte not stored", 32'(vol_l), 32'h22);
    chk("R10 new write stored", 32'(vol_r), 32'h33);

    // R10 abort inside address phase, then a read
    quiet = 0;
    bus_start();
    put_bit(1); put_bit(0); put_bit(0);
    i2c_read(7'h5B, st);
    chk("R10 restart address read", 32'(st[1:0]), 32'b01);

    // R8 reset mid-run
    quiet = 0;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    model_reset();
    chk("R8 reset restores mute", 32'(dut_vec), 32'(exp_vec()));
    rst_n = 1;
    repeat (4) @(negedge clk);
    quiet = 1;
    i2c_read(7'h5B, st);
    chk("R8 por flag after reset", 32'(st[1:0]), 32'b11);

    repeat (20) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule